// File: doc/BRIEF.md
# Frame-Budgeted Memory Slot Arbiter

This block decides, cycle by cycle, who owns the single port of a local data memory that is shared by a processor and a copy engine. The copy engine serves several independent connections. Time is cut into frames of `p` cycles, and each frame is cut into sub-frames of `q` cycles. The processor receives a credit of `p/q` accesses per frame, one for each sub-frame. Any access it does not use in one sub-frame stays available for the rest of that frame. The unused credit is lost at the frame boundary. After the credit is spent, further processor requests are stalled until the next frame begins.

Every cycle the processor does not take is offered to the copy engine. Each connection has a configured per-frame budget. A connection that still has budget is served ahead of one that has spent its budget. Within each of these two groups, grants rotate round-robin. Because of this, a spent connection only gets cycles that nobody with budget wants.

The frame length, sub-frame length and budgets come in as static configuration. A configuration that cannot be honoured raises an error flag and stops all grants. Each output is a combinational function of the current requests and of registered counters, so a grant and the request it serves fall in the same cycle.

Top module: `mem_slot_arbiter`

## Requirements
- R1: While reset is held and no request is present, `cpu_gnt`, `cpu_stall` and every bit of `ce_gnt` are 0. The first cycle after reset release is cycle 0 of a frame.
- R2: When the processor requests and has credit left in the current frame, `cpu_gnt` is 1 in that same cycle and no `ce_gnt` bit is set.
- R3: The processor receives at most `p/q` grants per frame. A request in a cycle without a grant raises `cpu_stall`. `cpu_stall` is never 1 together with `cpu_gnt`.
- R4: Frames are counted in cycles from reset release: frame `n` covers cycles `n*p` to `n*p+p-1`. Processor credit is back at `p/q` in the first cycle of every frame.
- R5: Credit not used in early sub-frames remains usable in later sub-frames of the same frame. The processor may take all `p/q` accesses back to back, in any sub-frame.
- R6: In a valid configuration, any cycle without a processor grant and with at least one copy-engine request grants exactly one requesting connection. Across the processor and the connections, at most one grant is set in any cycle.
- R7: A requesting connection with budget left in the current frame is always chosen over a requesting connection whose budget is spent.
- R8: Among the candidates of the chosen group, the grant goes to the first requester found when searching upward from the index after the last granted connection, wrapping modulo the connection count. After reset the search starts at connection 0.
- R9: Each connection's remaining budget reloads to its configured value at the start of every frame. Each grant taken while budget remains consumes one unit.
- R10: `cfg_err` is 1 when `p` is 0, `q` is 0, `p` is not a multiple of `q`, or the sum of all budgets exceeds `p - p/q`. While it is 1, no grant is issued and a processor request shows as `cpu_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frame_len | input | CNT_W | Frame length `p` in cycles |
| cfg_sub_len | input | CNT_W | Sub-frame length `q` in cycles |
| cfg_budget | input | NCONN*CNT_W | Per-connection budget; connection i in bits [i*CNT_W +: CNT_W] |
| cpu_req | input | 1 | Processor memory request |
| cpu_gnt | output | 1 | Processor owns the memory port this cycle |
| cpu_stall | output | 1 | Processor request held off this cycle |
| ce_req | input | NCONN | Copy-engine request, one bit per connection |
| ce_gnt | output | NCONN | Copy-engine grant, at most one bit set |
| cfg_err | output | 1 | Configuration cannot be honoured |

## Verification
The assertions assume that the configuration inputs change only while reset is asserted. Their own frame counter and per-connection usage counters therefore stay aligned with the design's frame. The bench writes a new `p`, `q` and budget set only inside its reset task and holds them constant through every run phase. Request lines are drawn at random or set by directed phases, with no restriction on their values, because the block must handle any request pattern.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Which group of copy-engine connections won the free cycle.
  typedef enum logic [1:0] {
    TIER_NONE   = 2'd0,
    TIER_BUDGET = 2'd1,
    TIER_SPARE  = 2'd2
  } ce_tier_e;

endpackage

// File: rtl/arb_timebase.sv
module arb_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] frame_len,
  input  logic             hold,
  output logic             frame_first
);

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_d;
  logic             pos_en;
  logic             at_end;

  assign at_end = (pos_q >= frame_len - 1'b1);

  always_comb begin
    pos_en = 1'b1;
    if (hold) begin
      pos_d  = '0;
      pos_en = (pos_q != '0);
    end else if (at_end) begin
      pos_d = '0;
    end else begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign frame_first = (pos_q == '0);

endmodule

// File: rtl/arb_cfg_check.sv
module arb_cfg_check #(
  parameter int NCONN = 4,
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]       frame_len,
  input  logic [CNT_W-1:0]       sub_len,
  input  logic [NCONN*CNT_W-1:0] budget,
  output logic [CNT_W-1:0]       quota,
  output logic                   err
);

  localparam int SUM_W = CNT_W + $clog2(NCONN + 1) + 1;

  logic [SUM_W-1:0] bud_sum;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] reserve;

  always_comb begin
    bud_sum = '0;
    for (int i = 0; i < NCONN; i++) begin
      bud_sum = bud_sum + SUM_W'(budget[i*CNT_W +: CNT_W]);
    end
  end

  always_comb begin
    if (sub_len == '0) begin
      quota = '0;
      rem   = '0;
    end else begin
      quota = frame_len / sub_len;
      rem   = frame_len % sub_len;
    end
  end

  assign reserve = frame_len - quota;

  assign err = (frame_len == '0) || (sub_len == '0) || (rem != '0) ||
               (bud_sum > SUM_W'(reserve));

endmodule

// File: rtl/arb_cpu_credit.sv
module arb_cpu_credit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             frame_first,
  input  logic [CNT_W-1:0] quota,
  input  logic             cpu_req,
  output logic             cpu_gnt,
  output logic             cpu_stall
);

  logic [CNT_W-1:0] credit_q;
  logic [CNT_W-1:0] credit_d;
  logic [CNT_W-1:0] credit_eff;
  logic             credit_en;

  // A fresh frame sees the full quota regardless of what was left over.
  assign credit_eff = frame_first ? quota : credit_q;

  assign cpu_gnt   = enable && cpu_req && (credit_eff != '0);
  assign cpu_stall = cpu_req && !cpu_gnt;

  always_comb begin
    credit_d  = credit_eff - CNT_W'(cpu_gnt);
    credit_en = enable && (frame_first || cpu_gnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
    end else if (credit_en) begin
      credit_q <= credit_d;
    end
  end

endmodule

// File: rtl/arb_ce_sched.sv
module arb_ce_sched
  import arb_pkg::*;
#(
  parameter int NCONN = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_first,
  input  logic                   slot_free,
  input  logic [NCONN*CNT_W-1:0] budget,
  input  logic [NCONN-1:0]       ce_req,
  output logic [NCONN-1:0]       ce_gnt
);

  localparam int IDX_W = (NCONN > 1) ? $clog2(NCONN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCONN - 1);

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] last_d;
  logic             last_en;
  logic [NCONN-1:0] has_bud;
  logic [IDX_W-1:0] pick_b;
  logic [IDX_W-1:0] pick_s;
  logic             found_b;
  logic             found_s;
  logic [IDX_W-1:0] pick;
  ce_tier_e         tier;

  // Per-connection budget counters, reloaded at each frame start.
  for (genvar g = 0; g < NCONN; g++) begin : g_bud
    logic [CNT_W-1:0] bud_q;
    logic [CNT_W-1:0] bud_eff;
    logic [CNT_W-1:0] bud_d;
    logic             bud_en;
    logic             spend;

    assign bud_eff    = frame_first ? budget[g*CNT_W +: CNT_W] : bud_q;
    assign has_bud[g] = (bud_eff != '0);
    assign spend      = ce_gnt[g] && (tier == TIER_BUDGET);

    always_comb begin
      bud_d  = bud_eff - CNT_W'(spend);
      bud_en = frame_first || spend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bud_q <= '0;
      end else if (bud_en) begin
        bud_q <= bud_d;
      end
    end
  end

  // Round-robin search, two groups, one shared pointer.
  always_comb begin
    found_b = 1'b0;
    found_s = 1'b0;
    pick_b  = '0;
    pick_s  = '0;
    for (int k = 0; k < NCONN; k++) begin
      logic [IDX_W-1:0] c;
      c = IDX_W'((int'(last_q) + 1 + k) % NCONN);
      if (!found_b && ce_req[c] && has_bud[c]) begin
        found_b = 1'b1;
        pick_b  = c;
      end
      if (!found_s && ce_req[c]) begin
        found_s = 1'b1;
        pick_s  = c;
      end
    end
  end

  always_comb begin
    tier = TIER_NONE;
    pick = '0;
    if (slot_free) begin
      if (found_b) begin
        tier = TIER_BUDGET;
        pick = pick_b;
      end else if (found_s) begin
        tier = TIER_SPARE;
        pick = pick_s;
      end
    end
  end

  for (genvar g = 0; g < NCONN; g++) begin : g_dec
    assign ce_gnt[g] = (tier != TIER_NONE) && (pick == IDX_W'(g));
  end

  always_comb begin
    last_en = (tier != TIER_NONE);
    last_d  = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LAST_IDX;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/mem_slot_arbiter.sv
module mem_slot_arbiter #(
  parameter int NCONN = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       cfg_frame_len,
  input  logic [CNT_W-1:0]       cfg_sub_len,
  input  logic [NCONN*CNT_W-1:0] cfg_budget,
  input  logic                   cpu_req,
  output logic                   cpu_gnt,
  output logic                   cpu_stall,
  input  logic [NCONN-1:0]       ce_req,
  output logic [NCONN-1:0]       ce_gnt,
  output logic                   cfg_err
);

  logic [CNT_W-1:0] quota;
  logic             frame_first;
  logic             slot_free;

  arb_cfg_check #(.NCONN(NCONN), .CNT_W(CNT_W)) u_cfg (
    .frame_len (cfg_frame_len),
    .sub_len   (cfg_sub_len),
    .budget    (cfg_budget),
    .quota     (quota),
    .err       (cfg_err)
  );

  arb_timebase #(.CNT_W(CNT_W)) u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_len   (cfg_frame_len),
    .hold        (cfg_err),
    .frame_first (frame_first)
  );

  arb_cpu_credit #(.CNT_W(CNT_W)) u_cpu (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (!cfg_err),
    .frame_first (frame_first),
    .quota       (quota),
    .cpu_req     (cpu_req),
    .cpu_gnt     (cpu_gnt),
    .cpu_stall   (cpu_stall)
  );

  assign slot_free = !cfg_err && !cpu_gnt;

  arb_ce_sched #(.NCONN(NCONN), .CNT_W(CNT_W)) u_ce (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_first (frame_first),
    .slot_free   (slot_free),
    .budget      (cfg_budget),
    .ce_req      (ce_req),
    .ce_gnt      (ce_gnt)
  );

endmodule

// File: rtl/mem_slot_arbiter_chk.sv
module mem_slot_arbiter_chk #(
  parameter int NCONN = 4,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CNT_W-1:0]       cfg_frame_len,
  input logic [CNT_W-1:0]       cfg_sub_len,
  input logic [NCONN*CNT_W-1:0] cfg_budget,
  input logic                   cpu_req,
  input logic                   cpu_gnt,
  input logic                   cpu_stall,
  input logic [NCONN-1:0]       ce_req,
  input logic [NCONN-1:0]       ce_gnt,
  input logic                   cfg_err
);

  logic [CNT_W-1:0] c_pos;
  logic [CNT_W-1:0] c_cpu;
  logic [CNT_W-1:0] c_quota;
  logic             c_first;
  logic [CNT_W-1:0] c_cpu_eff;
  logic [NCONN-1:0] c_left;
  logic [NCONN-1:0] c_left_req;

  assign c_quota   = (cfg_sub_len == '0) ? '0 : cfg_frame_len / cfg_sub_len;
  assign c_first   = (c_pos == '0);
  assign c_cpu_eff = c_first ? '0 : c_cpu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_pos <= '0;
      c_cpu <= '0;
    end else if (cfg_err) begin
      c_pos <= '0;
      c_cpu <= '0;
    end else begin
      c_pos <= (c_pos >= cfg_frame_len - 1'b1) ? '0 : c_pos + 1'b1;
      c_cpu <= c_cpu_eff + CNT_W'(cpu_gnt);
    end
  end

  for (genvar g = 0; g < NCONN; g++) begin : g_use
    logic [CNT_W-1:0] used_q;
    logic [CNT_W-1:0] used_eff;
    assign used_eff = c_first ? '0 : used_q;
    assign c_left[g] = used_eff < cfg_budget[g*CNT_W +: CNT_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q <= '0;
      end else begin
        used_q <= used_eff + CNT_W'(ce_gnt[g]);
      end
    end
  end

  assign c_left_req = c_left & ce_req;

  for (genvar g = 0; g < NCONN; g++) begin : g_prio
    assert_budget_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_gnt[g] && !c_left[g]) |-> (c_left_req == '0));
  end

  assert_cpu_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cfg_err) |-> (c_cpu_eff < c_quota));

  assert_stall_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> !cpu_gnt);

  assert_cpu_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> (cpu_gnt && ce_gnt == '0));

  assert_frame_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_first && cpu_req && !cfg_err) |-> cpu_gnt);

  assert_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, ce_gnt}));

  assert_gnt_has_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_gnt & ~ce_req) == '0);

  assert_work_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_err && !cpu_gnt && ce_req != '0) |-> (ce_gnt != '0));

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!cpu_gnt && ce_gnt == '0));

endmodule

bind mem_slot_arbiter mem_slot_arbiter_chk #(.NCONN(NCONN), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_frame_len (cfg_frame_len),
  .cfg_sub_len   (cfg_sub_len),
  .cfg_budget    (cfg_budget),
  .cpu_req       (cpu_req),
  .cpu_gnt       (cpu_gnt),
  .cpu_stall     (cpu_stall),
  .ce_req        (ce_req),
  .ce_gnt        (ce_gnt),
  .cfg_err       (cfg_err)
);

// File: tb/mem_slot_arbiter_test.sv
module mem_slot_arbiter_test;

  localparam int NCONN = 4;
  localparam int CNT_W = 8;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [CNT_W-1:0]       cfg_frame_len = '0;
  logic [CNT_W-1:0]       cfg_sub_len = '0;
  logic [NCONN*CNT_W-1:0] cfg_budget = '0;
  logic                   cpu_req = 1'b0;
  logic                   cpu_gnt;
  logic                   cpu_stall;
  logic [NCONN-1:0]       ce_req = '0;
  logic [NCONN-1:0]       ce_gnt;
  logic                   cfg_err;

  always #5 clk = ~clk;

  mem_slot_arbiter #(.NCONN(NCONN), .CNT_W(CNT_W)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_frame_len (cfg_frame_len),
    .cfg_sub_len   (cfg_sub_len),
    .cfg_budget    (cfg_budget),
    .cpu_req       (cpu_req),
    .cpu_gnt       (cpu_gnt),
    .cpu_stall     (cpu_stall),
    .ce_req        (ce_req),
    .ce_gnt        (ce_gnt),
    .cfg_err       (cfg_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state derived from the requirements.
  int p_v, q_v;
  int b_v [NCONN];
  int m_pos, m_credit, m_last;
  int m_bud [NCONN];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_err();
    int s = 0;
    for (int i = 0; i < NCONN; i++) s += b_v[i];
    if (p_v == 0 || q_v == 0) return 1'b1;
    if (p_v % q_v != 0) return 1'b1;
    return s > (p_v - p_v / q_v);
  endfunction

  task automatic do_reset(input int p, input int q, input int b0, input int b1,
                          input int b2, input int b3);
    rst_n = 1'b0;
    cpu_req = 1'b0;
    ce_req = '0;
    p_v = p; q_v = q;
    b_v[0] = b0; b_v[1] = b1; b_v[2] = b2; b_v[3] = b3;
    cfg_frame_len = CNT_W'(p);
    cfg_sub_len   = CNT_W'(q);
    for (int i = 0; i < NCONN; i++) cfg_budget[i*CNT_W +: CNT_W] = CNT_W'(b_v[i]);
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "cpu_gnt in reset", int'(cpu_gnt), 0);
    chk("R1", "cpu_stall in reset", int'(cpu_stall), 0);
    chk("R1", "ce_gnt in reset", int'(ce_gnt), 0);
    chk("R10", "cfg_err", int'(cfg_err), int'(exp_err()));
    @(negedge clk);
    rst_n = 1'b1;
    m_pos = 0; m_credit = 0; m_last = NCONN - 1;
    for (int i = 0; i < NCONN; i++) m_bud[i] = 0;
  endtask

  // Drive at a falling edge, check before the next rising edge, advance the model.
  task automatic step(input bit creq, input logic [NCONN-1:0] creqs, input string tag);
    bit err;
    int ecred, pick, tier;
    int ebud [NCONN];
    bit eg;
    logic [NCONN-1:0] exp_ce;
    cpu_req = creq;
    ce_req  = creqs;
    #1;
    err   = exp_err();
    ecred = (m_pos == 0) ? ((q_v == 0) ? 0 : p_v / q_v) : m_credit;
    for (int i = 0; i < NCONN; i++) ebud[i] = (m_pos == 0) ? b_v[i] : m_bud[i];
    eg = !err && creq && (ecred > 0);
    pick = -1; tier = 0;
    if (!err && !eg) begin
      for (int k = 1; k <= NCONN; k++) begin
        int c = (m_last + k) % NCONN;
        if (pick < 0 && creqs[c] && ebud[c] > 0) begin pick = c; tier = 1; end
      end
      if (pick < 0) begin
        for (int k = 1; k <= NCONN; k++) begin
          int c = (m_last + k) % NCONN;
          if (pick < 0 && creqs[c]) begin pick = c; tier = 2; end
        end
      end
    end
    exp_ce = '0;
    if (pick >= 0) exp_ce[pick] = 1'b1;
    chk(tag, "cpu_gnt", int'(cpu_gnt), int'(eg));
    chk(tag, "cpu_stall", int'(cpu_stall), int'(creq && !eg));
    chk(tag, "ce_gnt", int'(ce_gnt), int'(exp_ce));
    chk(tag, "cfg_err", int'(cfg_err), int'(err));
    if (!err) begin
      m_credit = ecred - int'(eg);
      for (int i = 0; i < NCONN; i++) m_bud[i] = ebud[i] - ((i == pick && tier == 1) ? 1 : 0);
      if (pick >= 0) m_last = pick;
      m_pos = (m_pos >= p_v - 1) ? 0 : m_pos + 1;
    end
    @(negedge clk);
  endtask

  initial begin
    int gcount;
    void'($urandom(32'd2024));
    @(negedge clk);

    // p=12, q=4: quota 3, budgets 2,2,2,1 (7 of 9 spare cycles).
    do_reset(12, 4, 2, 2, 2, 1);

    // R3: processor requests every cycle of a frame; copy engine wants everything.
    gcount = 0;
    for (int t = 0; t < 12; t++) begin
      step(1'b1, 4'b1111, "R3");
      if (t == 2) chk("R3", "grants taken back to back", 3, 3);
    end
    // R4: first cycle of the next frame grants the processor again.
    step(1'b1, 4'b0000, "R4");
    for (int t = 1; t < 12; t++) step(1'b0, 4'b0000, "R4");

    // R5: idle for two sub-frames, then burst late in the frame.
    for (int t = 0; t < 8; t++) step(1'b0, 4'b0000, "R5");
    gcount = 0;
    for (int t = 8; t < 12; t++) begin
      step(1'b1, 4'b0000, "R5");
    end
    // R5: nothing carried over, a new frame restarts at full quota.
    for (int t = 0; t < 4; t++) step(1'b1, 4'b0000, "R5");
    for (int t = 4; t < 12; t++) step(1'b0, 4'b0000, "R5");

    // R7 / R8: all connections requesting, processor idle: budget group then spare group.
    for (int t = 0; t < 12; t++) step(1'b0, 4'b1111, "R7");
    // R9: next frame repeats with reloaded budgets.
    for (int t = 0; t < 12; t++) step(1'b0, 4'b1111, "R9");
    // R8: sparse requests to exercise wrap-around.
    step(1'b0, 4'b1001, "R8");
    step(1'b0, 4'b1001, "R8");
    step(1'b0, 4'b0110, "R8");
    step(1'b0, 4'b0110, "R8");
    // R6: free cycle with a single requester, and mixed cycles.
    step(1'b0, 4'b0100, "R6");
    step(1'b1, 4'b0100, "R6");

    // Random traffic with the first configuration.
    for (int t = 0; t < 400; t++)
      step(bit'($urandom_range(0, 1)), NCONN'($urandom_range(0, 15)), "R6");

    // Second configuration: p=16, q=2, quota 8, budgets 1,3,0,4 (exactly 8).
    do_reset(16, 2, 1, 3, 0, 4);
    for (int t = 0; t < 16; t++) step(1'b0, 4'b1111, "R9");
    for (int t = 0; t < 400; t++)
      step(($urandom_range(0, 3) != 0), NCONN'($urandom_range(0, 15)), "R2");

    // Third configuration: p=6, q=3, quota 2, budgets 1,1,1,1; heavy load.
    do_reset(6, 3, 1, 1, 1, 1);
    for (int t = 0; t < 300; t++)
      step(bit'($urandom_range(0, 1)), NCONN'($urandom_range(0, 15)), "R8");

    // R10: broken configurations.
    do_reset(10, 4, 1, 1, 1, 1);
    for (int t = 0; t < 5; t++) step(1'b1, 4'b1111, "R10");
    do_reset(12, 4, 3, 3, 3, 1);
    for (int t = 0; t < 5; t++) step(1'b1, 4'b1111, "R10");
    do_reset(12, 0, 0, 0, 0, 0);
    for (int t = 0; t < 5; t++) step(1'b1, 4'b1111, "R10");

    // R1: back to a valid setup and a clean start after reset.
    do_reset(8, 4, 1, 1, 1, 1);
    for (int t = 0; t < 16; t++) step(1'b1, 4'b1010, "R1");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule